// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a behavioural model of a synchronous static RAM with a pipelined read path and a two-bit burst counter. Each access is one word made of byte lanes. Every lane holds eight data bits and, when enabled by a parameter, one parity bit stored beside them. Every control, address and write-data input is taken on the rising clock edge. Read data leaves through an output register, so a read accepted at one edge shows on the data bus after the following edge.

An access begins on one of two start strobes. The first strobe always starts a read and only counts while the first active-low enable is low. The second strobe starts a read or a write, depending on the write controls. The three enables decide selection only in a cycle that carries a strobe. Once a burst has started, later cycles without a strobe either step the low two address bits or hold them. Stepping is linear or interleaved, as chosen by a mode input. A snooze input parks the block in a power-down state, and the array keeps its contents while it is parked.

The control is a five-state machine. `ST_DESEL` is idle and deselected. `ST_SEL` is inside a burst. `ST_ZZ_ENTER` is the first snooze cycle, `ST_ZZ_SLEEP` is parked, and `ST_ZZ_WAKE` is recovery. The transitions are as follows:
- In `ST_DESEL` or `ST_SEL`, snooze high moves to `ST_ZZ_ENTER`.
- In `ST_DESEL` or `ST_SEL`, a valid start moves to `ST_SEL`.
- In `ST_DESEL` or `ST_SEL`, a deselecting strobe moves to `ST_DESEL`.
- `ST_ZZ_ENTER` moves to `ST_ZZ_SLEEP` if snooze is still high, and to `ST_ZZ_WAKE` otherwise.
- `ST_ZZ_SLEEP` stays while snooze is high and moves to `ST_ZZ_WAKE` when it falls.
- `ST_ZZ_WAKE` moves to `ST_DESEL` if snooze is low, and back to `ST_ZZ_ENTER` if it is high.

Top module: `burst_sram`

## Requirements
- R1: A read accepted at clock edge N puts its word on `dq_out`, with `dq_oe` high, in the cycle after edge N+1. The output is not yet valid in the cycle between edges N and N+1.
- R2: In an accepted write-capable cycle with `glb_wr_n` low, all lanes are written from `dq_in`, parity bits included, whatever `bw_en_n` and `byte_wr_n` are.
- R3: With `glb_wr_n` high and `bw_en_n` low, lane i is written only when `byte_wr_n[i]` is low. Lane i sits at `dq[i*9 +: 9]`: bits 7:0 of the lane are data and bit 8 is its parity. Lane 0 is bits 8:0 and lane 1 is bits 17:9.
- R4: A write-capable cycle with `glb_wr_n` high, and either `bw_en_n` high or every `byte_wr_n` bit high, is a read of the same address.
- R5: The enables `ce0_n`, `ce1` and `ce2_n` are looked at only in a strobe cycle. Selection requires `ce0_n`=0, `ce1`=1 and `ce2_n`=0. Changing them in a cycle without a strobe leaves a running burst unaffected.
- R6: A strobe cycle with any enable inactive deselects the block. It does not access the array, the bus stays undriven, and later cycles without a strobe neither read nor write until a new start.
- R7: `strb_proc_n` low is ignored when `ce0_n` is high, and the cycle then behaves as if that strobe were absent. Otherwise `strb_proc_n` low starts a read from `addr` even if the write controls ask for a write and `strb_ctl_n` is also low.
- R8: `strb_ctl_n` low, with `strb_proc_n` high and all enables active, starts a read or a write at `addr` according to R2 to R4.
- R9: In `ST_SEL`, a cycle with both strobes high and `adv_n` low steps the burst. After k steps from a start address with low bits s, the low two bits are (s+k) mod 4 when `burst_lin`=1 and s XOR k when `burst_lin`=0. The upper address bits are kept.
- R10: In `ST_SEL`, a cycle with both strobes high and `adv_n` high reuses the previous address for a read or a write.
- R11: `dq_oe` is high only for read data, and only while `oe_n` is low. It is low after reset and in the output slot of any write cycle.
- R12: Snooze sampled high ignores that cycle and every cycle until recovery. The block is parked after two snooze cycles. The first two edges with snooze low are still ignored. The array keeps its contents throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | AW | External word address |
| strb_proc_n | input | 1 | Read-start strobe, active low, gated by `ce0_n` |
| strb_ctl_n | input | 1 | Read/write-start strobe, active low |
| adv_n | input | 1 | Burst step (low) or hold (high) when no strobe |
| burst_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| glb_wr_n | input | 1 | Write all lanes, active low |
| bw_en_n | input | 1 | Enables per-lane writes, active low |
| byte_wr_n | input | BYTES | Per-lane write selects, active low |
| ce0_n | input | 1 | Enable, active low |
| ce1 | input | 1 | Enable, active high |
| ce2_n | input | 1 | Enable, active low |
| oe_n | input | 1 | Output enable, active low |
| snooze | input | 1 | Power-down request |
| dq_in | input | BYTES*(8+PAR_BITS) | Write data |
| dq_out | output | BYTES*(8+PAR_BITS) | Registered read data |
| dq_oe | output | 1 | Bus drive enable for `dq_out` |

## Verification
The bound checker watches four things on every cycle:
- The bus is driven only two edges after an accepted read.
- The bus is never driven while parked.
- A step keeps the upper address bits unchanged.
- A deselecting strobe is followed by an undriven output slot.

The remaining behaviour can only be shown by the bench's scenarios, which compare data words against a model array:
- Lane masking.
- The read fallback when no lane is selected.
- The linear and interleaved orderings.
- Holds inside a burst.
- Write attempts ignored while deselected or in snooze.
- Retention of contents across snooze.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    typedef enum logic [2:0] {
        SLOT_IDLE,
        SLOT_DESEL,
        SLOT_START_RD,
        SLOT_START_CTL,
        SLOT_NEXT,
        SLOT_HOLD
    } slot_e;

    typedef enum logic [2:0] {
        ST_DESEL,
        ST_SEL,
        ST_ZZ_ENTER,
        ST_ZZ_SLEEP,
        ST_ZZ_WAKE
    } st_e;

    // low two address bits of a burst after `step` advances
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       linear);
        return linear ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_burst_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic             strb_proc_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             ce2_n,
    input  logic             glb_wr_n,
    input  logic             bw_en_n,
    input  logic [BYTES-1:0] byte_wr_n,
    input  logic             selected,
    output slot_e            slot,
    output logic             wr_req,
    output logic [BYTES-1:0] wmask
);

    logic proc_live;
    logic en_all;

    always_comb begin
        proc_live = !strb_proc_n && !ce0_n;
        en_all    = !ce0_n && ce1 && !ce2_n;

        if (proc_live) begin
            slot = en_all ? SLOT_START_RD : SLOT_DESEL;
        end else if (!strb_ctl_n) begin
            slot = en_all ? SLOT_START_CTL : SLOT_DESEL;
        end else if (selected) begin
            slot = adv_n ? SLOT_HOLD : SLOT_NEXT;
        end else begin
            slot = SLOT_IDLE;
        end

        if (!glb_wr_n) begin
            wmask = '1;
        end else if (!bw_en_n) begin
            wmask = ~byte_wr_n;
        end else begin
            wmask = '0;
        end

        wr_req = ((slot == SLOT_START_CTL) || (slot == SLOT_NEXT) ||
                  (slot == SLOT_HOLD)) && (|wmask);
    end

endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
    import sram_burst_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          linear,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] eff_addr
);

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_use;

    always_comb begin
        cnt_use = adv ? (cnt_q + 2'd1) : cnt_q;
        if (load) begin
            eff_addr = ext_addr;
        end else begin
            eff_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_use, linear)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= ext_addr;
            cnt_q  <= '0;
        end else if (adv) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int AW    = 6,
    parameter int BYTES = 2,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic [BYTES-1:0]    we,
    input  logic [AW-1:0]       waddr,
    input  logic [BYTES*LW-1:0] wdata,
    input  logic                re,
    input  logic [AW-1:0]       raddr,
    output wire  [BYTES*LW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [LW-1:0] cells [DEPTH];
        logic [LW-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we[g]) begin
                cells[waddr] <= wdata[g*LW +: LW];
            end
            if (re) begin
                rd_q <= cells[raddr];
            end
        end

        assign rdata[g*LW +: LW] = rd_q;
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import sram_burst_pkg::*;
#(
    parameter int AW       = 6,
    parameter int BYTES    = 2,
    parameter int PAR_BITS = 1,
    localparam int LW      = 8 + PAR_BITS,
    localparam int DW      = BYTES * LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             strb_proc_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             burst_lin,
    input  logic             glb_wr_n,
    input  logic             bw_en_n,
    input  logic [BYTES-1:0] byte_wr_n,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             ce2_n,
    input  logic             oe_n,
    input  logic             snooze,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);

    st_e              st_q;
    st_e              st_nx;
    slot_e            slot;
    logic             wr_req;
    logic [BYTES-1:0] wmask;
    logic             accept;
    logic             ld_burst;
    logic             adv_burst;
    logic             wr_fire;
    logic             rd_fire;
    logic [AW-1:0]    eff_addr;
    logic             rd_q;
    logic [AW-1:0]    rd_addr_q;
    logic             drive_q;
    wire  [DW-1:0]    arr_rdata;

    sram_cmd_decode #(.BYTES(BYTES)) dec_i (
        .strb_proc_n (strb_proc_n),
        .strb_ctl_n  (strb_ctl_n),
        .adv_n       (adv_n),
        .ce0_n       (ce0_n),
        .ce1         (ce1),
        .ce2_n       (ce2_n),
        .glb_wr_n    (glb_wr_n),
        .bw_en_n     (bw_en_n),
        .byte_wr_n   (byte_wr_n),
        .selected    (st_q == ST_SEL),
        .slot        (slot),
        .wr_req      (wr_req),
        .wmask       (wmask)
    );

    sram_burst_addr #(.AW(AW)) bur_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_burst),
        .adv      (adv_burst),
        .linear   (burst_lin),
        .ext_addr (addr),
        .eff_addr (eff_addr)
    );

    sram_lane_array #(.AW(AW), .BYTES(BYTES), .LW(LW)) arr_i (
        .clk   (clk),
        .we    (wr_fire ? wmask : '0),
        .waddr (eff_addr),
        .wdata (dq_in),
        .re    (rd_q),
        .raddr (rd_addr_q),
        .rdata (arr_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_DESEL;
        end else begin
            st_q <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_DESEL, ST_SEL: begin
                if (snooze) begin
                    st_nx = ST_ZZ_ENTER;
                end else if (slot == SLOT_DESEL) begin
                    st_nx = ST_DESEL;
                end else if ((slot == SLOT_START_RD) || (slot == SLOT_START_CTL)) begin
                    st_nx = ST_SEL;
                end
            end
            ST_ZZ_ENTER: st_nx = snooze ? ST_ZZ_SLEEP : ST_ZZ_WAKE;
            ST_ZZ_SLEEP: st_nx = snooze ? ST_ZZ_SLEEP : ST_ZZ_WAKE;
            ST_ZZ_WAKE:  st_nx = snooze ? ST_ZZ_ENTER : ST_DESEL;
            default:     st_nx = ST_DESEL;
        endcase
    end

    // per-cycle actions
    always_comb begin
        accept    = ((st_q == ST_DESEL) || (st_q == ST_SEL)) && !snooze;
        ld_burst  = accept && ((slot == SLOT_START_RD) || (slot == SLOT_START_CTL));
        adv_burst = accept && (slot == SLOT_NEXT);
        wr_fire   = accept && wr_req;
        rd_fire   = accept && ((slot == SLOT_START_RD) ||
                    (((slot == SLOT_START_CTL) || (slot == SLOT_NEXT) ||
                      (slot == SLOT_HOLD)) && !wr_req));
    end

    // read pipeline: command stage, then array output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            rd_addr_q <= '0;
            drive_q   <= 1'b0;
        end else begin
            rd_q      <= rd_fire;
            rd_addr_q <= eff_addr;
            drive_q   <= rd_q;
        end
    end

    assign dq_out = arr_rdata;
    assign dq_oe  = drive_q && !oe_n;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import sram_burst_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dq_oe,
    input st_e           st_q,
    input logic          accept,
    input slot_e         slot,
    input logic          rd_fire,
    input logic [AW-1:0] eff_addr
);

    AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(rd_fire, 2)); // R11

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ZZ_SLEEP) |-> !dq_oe); // R12

    AST_STEP_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && slot == SLOT_NEXT) |-> (eff_addr[AW-1:2] == $past(eff_addr[AW-1:2]))); // R9

    AST_DESEL_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && slot == SLOT_DESEL) |=> ##1 !dq_oe); // R6

endmodule

bind burst_sram burst_sram_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dq_oe    (dq_oe),
    .st_q     (st_q),
    .accept   (accept),
    .slot     (slot),
    .rd_fire  (rd_fire),
    .eff_addr (eff_addr)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;

    localparam int CLK_NS = 10;
    localparam int AW     = 6;
    localparam int DEPTH  = 1 << AW;
    localparam int DW     = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic          strb_proc_n, strb_ctl_n, adv_n, burst_lin;
    logic          glb_wr_n, bw_en_n;
    logic [1:0]    byte_wr_n;
    logic          ce0_n, ce1, ce2_n, oe_n, snooze;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] mdl [DEPTH];

    burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strb_proc_n(strb_proc_n),
        .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .burst_lin(burst_lin),
        .glb_wr_n(glb_wr_n), .bw_en_n(bw_en_n), .byte_wr_n(byte_wr_n),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .oe_n(oe_n), .snooze(snooze),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'(a * 499 + s * 4951 + 677);
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [1:0] mask);
        logic [DW-1:0] r;
        r = old_w;
        if (mask[0]) r[8:0]  = new_w[8:0];
        if (mask[1]) r[17:9] = new_w[17:9];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        strb_proc_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
        glb_wr_n = 1'b1; bw_en_n = 1'b1; byte_wr_n = 2'b11;
        ce0_n = 1'b0; ce1 = 1'b1; ce2_n = 1'b0; oe_n = 1'b0; snooze = 1'b0;
        dq_in = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ctl_write(input int a, input logic [DW-1:0] d, input logic gw,
                             input logic bwe, input logic [1:0] bwn);
        logic [1:0] m;
        idle();
        strb_ctl_n = 1'b0; addr = AW'(a); dq_in = d;
        glb_wr_n = gw; bw_en_n = bwe; byte_wr_n = bwn;
        tick();
        m = !gw ? 2'b11 : (!bwe ? ~bwn : 2'b00);
        mdl[a] = merge(mdl[a], d, m);
    endtask

    task automatic ctl_read_chk(input int a, input string tag);
        idle();
        strb_ctl_n = 1'b0; addr = AW'(a);
        tick();
        idle();
        tick();
        chk({tag, " oe"}, dq_oe, 1);
        chk({tag, " data"}, dq_out, mdl[a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(); burst_lin = 1'b1; addr = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R11 reset undriven", dq_oe, 0);

        // R2: global writes fill the array, lane selects varied and overridden
        for (int a = 0; a < DEPTH; a++)
            ctl_write(a, pat(a, 0), 1'b0, a[2], a[1:0]);

        // R1 R8: back-to-back pipelined reads of every word
        for (int a = 0; a < DEPTH; a++) begin
            idle(); strb_ctl_n = 1'b0; addr = AW'(a);
            tick();
            if (a > 0) chk("R8 sweep read", dq_out, mdl[a-1]);
        end
        idle(); tick();
        chk("R8 sweep last", dq_out, mdl[DEPTH-1]);

        // R1 latency
        idle(); strb_ctl_n = 1'b0; addr = 6'd5; tick();
        idle(); oe_n = 1'b0; strb_proc_n = 1'b0; ce1 = 1'b0; tick();
        chk("R1 one edge", dq_oe, 1);
        idle(); tick();
        chk("R1 data", dq_out, mdl[5]);

        // R3 R4: all lane-select combos with global write high
        for (int c = 0; c < 8; c++) begin
            logic [2:0] cc;
            cc = 3'(c);
            ctl_write(c, pat(c, 1), 1'b1, cc[2], cc[1:0]);
            idle(); tick();
            if (cc[2] || cc[1:0] == 2'b11) begin
                chk("R4 read fallback oe", dq_oe, 1);
                chk("R4 read fallback data", dq_out, mdl[c]);
            end else begin
                chk("R11 write slot undriven", dq_oe, 0);
            end
        end
        for (int c = 0; c < 8; c++) ctl_read_chk(c, "R3 lane result");

        // R2: global write overrides any lane selects
        for (int c = 0; c < 4; c++) begin
            logic [1:0] b;
            b = 2'(c);
            ctl_write(8 + c, pat(8 + c, 3), 1'b0, 1'b0, b);
        end
        for (int c = 0; c < 4; c++) ctl_read_chk(8 + c, "R2 global");

        // R9 R10: read bursts in both orders from every start offset
        for (int lin = 0; lin < 2; lin++) begin
            for (int s = 0; s < 4; s++) begin
                int steps [5] = '{0, 1, 1, 2, 3};
                int ea [5];
                burst_lin = lin[0];
                for (int k = 0; k < 5; k++)
                    ea[k] = 20 + (lin != 0 ? ((s + steps[k]) % 4) : (s ^ steps[k]));
                for (int k = 0; k < 5; k++) begin
                    idle();
                    if (k == 0) begin
                        strb_ctl_n = 1'b0; addr = AW'(20 + s);
                    end else begin
                        adv_n = (k == 2); addr = 6'd63;
                    end
                    tick();
                    if (k == 3) chk("R10 hold read", dq_out, mdl[ea[k-1]]);
                    else if (k > 0) chk("R9 burst read", dq_out, mdl[ea[k-1]]);
                end
                idle(); tick();
                chk("R9 burst tail", dq_out, mdl[ea[4]]);
            end
        end

        // R9: interleaved write burst starting at low bits 01
        burst_lin = 1'b0;
        begin
            int wa [4] = '{33, 32, 35, 34};
            for (int k = 0; k < 4; k++) begin
                idle(); glb_wr_n = 1'b0; dq_in = pat(wa[k], 7);
                if (k == 0) begin strb_ctl_n = 1'b0; addr = 6'd33; end
                else adv_n = 1'b0;
                tick();
                mdl[wa[k]] = pat(wa[k], 7);
            end
            for (int k = 0; k < 4; k++) ctl_read_chk(wa[k], "R9 write burst");
        end
        burst_lin = 1'b1;

        // R7: first strobe reads even with writes requested, and wins over second strobe
        idle(); strb_proc_n = 1'b0; addr = 6'd40; glb_wr_n = 1'b0; dq_in = ~mdl[40]; tick();
        idle(); tick();
        chk("R7 proc read", dq_out, mdl[40]);
        idle(); strb_proc_n = 1'b0; strb_ctl_n = 1'b0; addr = 6'd41; glb_wr_n = 1'b0;
        dq_in = ~mdl[41]; tick();
        idle(); tick();
        chk("R7 priority read", dq_out, mdl[41]);
        ctl_read_chk(40, "R7 no write 40");
        ctl_read_chk(41, "R7 no write 41");

        // R7: first strobe with ce0_n high acts as a plain step
        idle(); strb_ctl_n = 1'b0; addr = 6'd44; tick();
        idle(); strb_proc_n = 1'b0; ce0_n = 1'b1; adv_n = 1'b0; addr = 6'd10; tick();
        chk("R7 start data", dq_out, mdl[44]);
        idle(); tick();
        chk("R7 ignored strobe stepped", dq_out, mdl[45]);

        // R6: first strobe with valid ce0_n but other enable off deselects
        idle(); strb_proc_n = 1'b0; ce1 = 1'b0; addr = 6'd3; tick();
        idle(); tick();
        chk("R6 proc deselect", dq_oe, 0);

        // R6: every inactive enable pattern on the second strobe
        for (int c = 0; c < 8; c++) begin
            logic [2:0] e;
            e = 3'(c);
            if (e != 3'b010) begin
                ctl_read_chk(50, "R6 pre");
                idle(); strb_ctl_n = 1'b0; ce0_n = e[0]; ce1 = e[1]; ce2_n = e[2];
                addr = 6'd51; tick();
                idle(); adv_n = 1'b0; glb_wr_n = 1'b0; dq_in = ~mdl[50]; tick();
                chk("R6 deselect slot", dq_oe, 0);
                idle(); glb_wr_n = 1'b0; dq_in = ~mdl[51]; tick();
                chk("R6 no continue", dq_oe, 0);
                idle(); tick();
                chk("R6 still idle", dq_oe, 0);
                ctl_read_chk(50, "R6 kept 50");
                ctl_read_chk(51, "R6 kept 51");
            end
        end

        // R5: enables changed mid-burst without a strobe
        idle(); strb_ctl_n = 1'b0; addr = 6'd56; tick();
        idle(); ce0_n = 1'b1; ce1 = 1'b0; ce2_n = 1'b1; adv_n = 1'b0; tick();
        chk("R5 start data", dq_out, mdl[56]);
        idle(); ce0_n = 1'b1; ce1 = 1'b0; tick();
        chk("R5 burst continues", dq_out, mdl[57]);

        // R11: output enable gates the bus
        idle(); strb_ctl_n = 1'b0; addr = 6'd12; tick();
        idle(); tick();
        oe_n = 1'b1; #1;
        chk("R11 oe high", dq_oe, 0);
        oe_n = 1'b0; #1;
        chk("R11 oe low", dq_oe, 1);
        chk("R11 oe data", dq_out, mdl[12]);

        // R12: snooze entry, parked, recovery, retention
        ctl_write(60, pat(60, 5), 1'b0, 1'b1, 2'b11);
        idle(); snooze = 1'b1; strb_ctl_n = 1'b0; glb_wr_n = 1'b0; addr = 6'd60;
        dq_in = ~mdl[60]; tick();
        tick();
        tick();
        chk("R12 parked undriven", dq_oe, 0);
        snooze = 1'b0; tick();
        idle(); strb_ctl_n = 1'b0; addr = 6'd60; tick();
        idle(); strb_ctl_n = 1'b0; addr = 6'd60; tick();
        chk("R12 recovery read ignored", dq_oe, 0);
        idle(); tick();
        chk("R12 first read oe", dq_oe, 1);
        chk("R12 retained", dq_out, mdl[60]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule